// File: doc/BRIEF.md
# Dual Audio Baud-Rate Clock Generator

This block derives audio bit-clock timing from a set of four reference strobes: three external references (A, B, C) and one internal reference. All timing is expressed as single-cycle clock-enable strobes in one fast clock domain. Two programmable dividers are provided. Divider A is meant for rates in the 44.1 kHz family and divider B for the 48 kHz family. Each divider counts strobes from a reference it picks itself. Its division ratio is a power-of-four prescale multiplied by an 8-bit count.

Each of eight serial audio channels owns an 8-bit selector. The selector routes a raw reference or one of the two divider outputs to that channel, or silences it. A ninth channel output has no selector and mirrors channel 7. A shared clock output follows either divider A or divider B under one control bit. Software programs the block through a single-cycle write port.

Top module: `audio_bclk_gen`

## Requirements
- R1: After reset every output is low, all channel selectors read 0x00, both divider source fields read 0, the steering bit reads 0, and both divide words read 0x0FF. With a continuous source strobe, each divider therefore pulses every 512 cycles.
- R2: A divide word (address 1 for divider A, address 2 for divider B, data bits [9:0]) divides by P × (N+1). N is bits [7:0]. P is 2, 8, 32 or 128 for bits [9:8] equal to 0, 1, 2 or 3.
- R3: The control word at address 0 selects each divider's source. Bits [22:20] serve divider A and bits [18:16] serve divider B. Code 0 counts ref_tick[0] (reference A), code 1 counts ref_tick[1] (reference B), code 2 counts ref_tick[3] (internal reference), and code 4 counts ref_tick[2] (reference C).
- R4: A divider whose source code is 3, 5, 6 or 7 produces no pulses.
- R5: Control bit 31 steers shared_tick. A value of 0 follows divider A and 1 follows divider B. The shared output is one cycle behind the divider.
- R6: Channel selectors are packed four per word. Address 3 holds channels 0–3 and address 4 holds channels 4–7, with channel k at bits (k mod 4)×8+7 : (k mod 4)×8. The codes are:
  - 0x01: ref_tick[0]
  - 0x02: ref_tick[1]
  - 0x03: ref_tick[2]
  - 0x10: divider A
  - 0x20: divider B
  
  Each channel output is the selected strobe delayed by one cycle.
- R7: Channel code 0x00 stops that channel. Every code not listed in R6 also yields no pulses.
- R8: chan_tick[8] always equals chan_tick[7].
- R9: A divider adopts a new divide word only at its terminal count. A write that lands on the same edge as a terminal count waits for the following terminal count.
- R10: Divider outputs are single-cycle pulses. Two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 4 | Reference strobes: [0] A, [1] B, [2] C, [3] internal |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| chan_tick | output | 9 | Per-channel clock enables; bit 8 mirrors bit 7 |
| shared_tick | output | 1 | Shared clock enable from divider A or B |

## Verification
Two events can coincide in the same edge: a write of a new divide word and the divider's terminal count. To provoke this, the bench synchronises to a divider pulse, counts cycles, and issues the write so that it lands either exactly on the terminal edge or one edge earlier. The result is judged from the next three pulse gaps. In the coinciding case the old period must repeat once before the new one appears. In the earlier case the new period must follow immediately.

// File: rtl/abg_pkg.sv
// Shared constants and helpers for the audio baud-rate clock generator.
// Assumes: reference strobe order [0]=A, [1]=B, [2]=C, [3]=internal.
package abg_pkg;

    localparam int REF_W   = 4;
    localparam int DIVW_W  = 10;
    localparam int CNT_W   = 15;
    localparam int CODE_W  = 8;

    // Divider source codes (control word fields)
    localparam logic [2:0] SRC_REF_A = 3'd0;
    localparam logic [2:0] SRC_REF_B = 3'd1;
    localparam logic [2:0] SRC_INT   = 3'd2;
    localparam logic [2:0] SRC_REF_C = 3'd4;

    // Channel selector codes
    localparam logic [CODE_W-1:0] CH_OFF   = 8'h00;
    localparam logic [CODE_W-1:0] CH_REF_A = 8'h01;
    localparam logic [CODE_W-1:0] CH_REF_B = 8'h02;
    localparam logic [CODE_W-1:0] CH_REF_C = 8'h03;
    localparam logic [CODE_W-1:0] CH_DIV_A = 8'h10;
    localparam logic [CODE_W-1:0] CH_DIV_B = 8'h20;

    localparam logic [DIVW_W-1:0] DIVW_RST = 10'h0FF;

    // Terminal count (total division minus one) for a divide word.
    function automatic logic [CNT_W-1:0] div_limit(input logic [DIVW_W-1:0] w);
        logic [CNT_W:0] t;
        logic [2:0]     sh;
        sh = {w[9:8], 1'b0} + 3'd1;
        t  = {{(CNT_W-7){1'b0}}, w[7:0]} + {{CNT_W{1'b0}}, 1'b1};
        t  = t << sh;
        return t[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/abg_regs.sv
// Register bank: control word, two divide words, packed channel selectors.
// Assumes: single-cycle writes; addresses 0 ctrl, 1 div A, 2 div B,
// 3.. channel groups of four. Unmapped addresses are ignored.
module abg_regs
    import abg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [31:0]                    wr_data,
    output logic                           out_sel,
    output logic [2:0]                     src_a,
    output logic [2:0]                     src_b,
    output logic [DIVW_W-1:0]              div_a,
    output logic [DIVW_W-1:0]              div_b,
    output logic [NUM_CH-1:0][CODE_W-1:0]  ch_code
);

    localparam int NUM_GRP = NUM_CH / 4;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIVA = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DIVB = ADDR_W'(2);
    localparam int GRP_BASE = 3;

    // Control word and divide words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sel <= 1'b0;
            src_a   <= SRC_REF_A;
            src_b   <= SRC_REF_A;
            div_a   <= DIVW_RST;
            div_b   <= DIVW_RST;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                out_sel <= wr_data[31];
                src_a   <= wr_data[22:20];
                src_b   <= wr_data[18:16];
            end
            if (wr_addr == A_DIVA) div_a <= wr_data[DIVW_W-1:0];
            if (wr_addr == A_DIVB) div_b <= wr_data[DIVW_W-1:0];
        end
    end

    // Channel selector groups, four 8-bit fields per word
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int f = 0; f < 4; f++) ch_code[g*4+f] <= CH_OFF;
            end else if (wr_en && wr_addr == ADDR_W'(GRP_BASE + g)) begin
                for (int f = 0; f < 4; f++) ch_code[g*4+f] <= wr_data[f*8 +: 8];
            end
        end
    end

    assert_div_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (div_a == DIVW_RST && div_b == DIVW_RST && ch_code == '0))
        else $error("divide words or selectors not at reset value");

endmodule

// File: rtl/abg_div.sv
// Programmable divider: counts strobes of a selected reference and emits
// one registered pulse per P*(N+1) strobes. The divide word is sampled
// only at terminal count. Assumes total division is at least 2.
module abg_div
    import abg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REF_W-1:0]  ref_tick,
    input  logic [2:0]        src_code,
    input  logic [DIVW_W-1:0] div_word,
    output logic              tick_o
);

    logic              src_hit;
    logic [DIVW_W-1:0] act_word;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;

    // Source strobe selection; undefined codes select nothing
    always_comb begin
        unique case (src_code)
            SRC_REF_A: src_hit = ref_tick[0];
            SRC_REF_B: src_hit = ref_tick[1];
            SRC_REF_C: src_hit = ref_tick[2];
            SRC_INT:   src_hit = ref_tick[3];
            default:   src_hit = 1'b0;
        endcase
    end

    // Terminal count of the active word
    assign lim = div_limit(act_word);

    // Strobe counter, active word reload and output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_word <= DIVW_RST;
            tick_o   <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (src_hit) begin
                if (cnt >= lim) begin
                    cnt      <= '0;
                    act_word <= div_word;
                    tick_o   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_word) |-> tick_o)
        else $error("divide word changed away from terminal count");

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim)
        else $error("divider count beyond terminal");

    assert_tick_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(src_hit))
        else $error("pulse without a source strobe");

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("adjacent divider pulses");

endmodule

// File: rtl/abg_chsel.sv
// Per-channel clock selector: registers the strobe picked by an 8-bit code.
// Assumes: code 0x00 and unlisted codes silence the channel.
module abg_chsel
    import abg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ref_ext,
    input  logic              div_a_tick,
    input  logic              div_b_tick,
    input  logic [CODE_W-1:0] sel_code,
    output logic              tick_o
);

    logic pick;

    // Decode selector code to a strobe
    always_comb begin
        case (sel_code)
            CH_REF_A: pick = ref_ext[0];
            CH_REF_B: pick = ref_ext[1];
            CH_REF_C: pick = ref_ext[2];
            CH_DIV_A: pick = div_a_tick;
            CH_DIV_B: pick = div_b_tick;
            default:  pick = 1'b0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) tick_o <= 1'b0;
        else        tick_o <= pick;
    end

    assert_stop_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == CH_OFF) |=> !tick_o)
        else $error("stopped channel produced a pulse");

endmodule

// File: rtl/audio_bclk_gen.sv
// Dual audio baud-rate clock generator top: register bank, two dividers,
// per-channel selectors and a steerable shared output. All clocks are
// clock-enable strobes in the clk domain. Assumes NUM_CH is a multiple of 4.
module audio_bclk_gen
    import abg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NUM_CH:0]   chan_tick,
    output logic              shared_tick
);

    logic                          out_sel;
    logic [2:0]                    src_a, src_b;
    logic [DIVW_W-1:0]             div_a, div_b;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_code;
    logic [1:0]                    div_tick;
    logic [NUM_CH-1:0]             ch_tick;

    abg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_sel(out_sel), .src_a(src_a), .src_b(src_b),
        .div_a(div_a), .div_b(div_b), .ch_code(ch_code)
    );

    // Two identical dividers, A then B
    for (genvar d = 0; d < 2; d++) begin : g_div
        abg_div u_div (
            .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
            .src_code((d == 0) ? src_a : src_b),
            .div_word((d == 0) ? div_a : div_b),
            .tick_o(div_tick[d])
        );
    end

    // One selector per programmable channel
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        abg_chsel u_sel (
            .clk(clk), .rst_n(rst_n), .ref_ext(ref_tick[2:0]),
            .div_a_tick(div_tick[0]), .div_b_tick(div_tick[1]),
            .sel_code(ch_code[k]), .tick_o(ch_tick[k])
        );
    end

    assign chan_tick = {ch_tick[NUM_CH-1], ch_tick};

    // Shared output steering register
    always_ff @(posedge clk) begin
        if (!rst_n) shared_tick <= 1'b0;
        else        shared_tick <= out_sel ? div_tick[1] : div_tick[0];
    end

    assert_shared_steer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shared_tick |-> $past(out_sel ? div_tick[1] : div_tick[0]))
        else $error("shared output not from steered divider");

endmodule

// File: tb/audio_bclk_gen_tb.sv
`timescale 1ns/1ps
module audio_bclk_gen_tb;

    localparam int NCH = 8;
    localparam int SHR = NCH + 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [3:0]     ref_tick;
    logic           wr_en;
    logic [2:0]     wr_addr;
    logic [31:0]    wr_data;
    logic [NCH:0]   chan_tick;
    logic           shared_tick;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    audio_bclk_gen #(.NUM_CH(NCH), .ADDR_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_tick(chan_tick), .shared_tick(shared_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit obs(input int i);
        if (i >= SHR) return shared_tick;
        return chan_tick[i];
    endfunction

    function automatic int total(input logic [9:0] w);
        return (int'(w[7:0]) + 1) << (1 + 2 * int'(w[9:8]));
    endfunction

    function automatic logic exp_ch(input logic [7:0] c, input logic [3:0] r);
        case (c)
            8'h01: return r[0];
            8'h02: return r[1];
            8'h03: return r[2];
            default: return 1'b0;
        endcase
    endfunction

    // called at a negedge; returns at the negedge after the write landed
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // sync to a pulse, then return the gap to the next one (-1 on timeout)
    task automatic measure(input int i, input int lim, output int p);
        int c;
        repeat (3) @(negedge clk);
        c = 0;
        while (!obs(i) && c < lim) begin @(negedge clk); c++; end
        if (!obs(i)) begin p = -1; return; end
        c = 0;
        do begin @(negedge clk); c++; end while (!obs(i) && c < lim);
        p = obs(i) ? c : -1;
    endtask

    task automatic count_pulses(input int i, input int win, output int n);
        n = 0;
        repeat (win) begin @(negedge clk); if (obs(i)) n++; end
    endtask

    // write div A = 0x001 k cycles after a pulse; report three gaps
    task automatic collide(input int k, output int g1, output int g2, output int g3);
        int c; int found; int last;
        c = 0; found = 0; last = 0; g1 = -1; g2 = -1; g3 = -1;
        while (found < 3 && c < 200) begin
            @(negedge clk); c++;
            if (c == k) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h001; end
            else wr_en = 1'b0;
            if (obs(0)) begin
                if (found == 0) g1 = c - last;
                else if (found == 1) g2 = c - last;
                else g3 = c - last;
                last = c; found++;
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int p, n, g1, g2, g3;
        logic [9:0] w;
        logic [NCH-1:0][7:0] cd;
        logic [NCH:0] expv;
        logic [NCH:0] stopm;
        logic [7:0] pool [4];
        pool[0] = 8'h04; pool[1] = 8'h30; pool[2] = 8'h11; pool[3] = 8'hFF;
        void'($urandom(32'h5EED_1234));

        rst_n = 1'b0; ref_tick = 4'hF; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(chan_tick == '0 && shared_tick == 1'b0, "R1 outputs low after reset",
              int'(chan_tick), 0);

        // R1: reset divide words give 512-cycle periods; R6 divider codes on ch0/ch1
        wr(3'd3, 32'h0000_2010);
        measure(0, 2000, p); check(p == 512, "R1 divider A reset period", p, 512);
        measure(1, 2000, p); check(p == 512, "R1 divider B reset period (R6 code 0x20)", p, 512);

        // R2: every prescale code at N=0, then at N=255 (descending)
        for (int c = 0; c < 4; c++) begin
            w = {c[1:0], 8'd0};
            wr(3'd1, {22'd0, w});
            measure(0, 40000, p); check(p == total(w), "R2 period N=0", p, total(w));
            if (c == 0) begin
                @(negedge clk);
                check(chan_tick[0] == 1'b0, "R10 pulse lasts one cycle", int'(chan_tick[0]), 0);
            end
        end
        for (int c = 3; c >= 0; c--) begin
            w = {c[1:0], 8'd255};
            wr(3'd1, {22'd0, w});
            measure(0, 40000, p); check(p == total(w), "R2 period N=255", p, total(w));
        end

        // R3: each divider source code counts only its own reference
        wr(3'd1, 32'h000); wr(3'd2, 32'h000);
        measure(0, 2000, p);
        for (int s = 0; s < 4; s++) begin
            logic [2:0] sc; logic [3:0] bitv;
            sc   = (s == 0) ? 3'd0 : (s == 1) ? 3'd1 : (s == 2) ? 3'd2 : 3'd4;
            bitv = (s == 0) ? 4'b0001 : (s == 1) ? 4'b0010 : (s == 2) ? 4'b1000 : 4'b0100;
            ref_tick = bitv;
            wr(3'd0, {9'd0, sc, 1'b0, sc, 16'd0});
            measure(0, 50, p); check(p == 2, "R3 divider A source", p, 2);
            measure(1, 50, p); check(p == 2, "R3 divider B source", p, 2);
            ref_tick = ~bitv;
            repeat (4) @(negedge clk);
            count_pulses(0, 40, n); check(n == 0, "R3 other references ignored", n, 0);
        end

        // R4: undefined source codes give no pulses
        ref_tick = 4'hF;
        for (int s = 0; s < 4; s++) begin
            logic [2:0] sc;
            sc = (s == 0) ? 3'd3 : (s == 1) ? 3'd5 : (s == 2) ? 3'd6 : 3'd7;
            wr(3'd0, {9'd0, sc, 1'b0, sc, 16'd0});
            repeat (4) @(negedge clk);
            count_pulses(0, 40, n); check(n == 0, "R4 divider A idle", n, 0);
            count_pulses(1, 40, n); check(n == 0, "R4 divider B idle", n, 0);
        end

        // R5: shared output steering
        wr(3'd0, 32'h0000_0000);
        wr(3'd2, 32'h100);
        measure(SHR, 200, p); check(p == 2, "R5 shared follows A", p, 2);
        wr(3'd0, 32'h8000_0000);
        measure(SHR, 200, p); check(p == 8, "R5 shared follows B", p, 8);

        // R9: write landing on the terminal edge vs one edge earlier
        wr(3'd1, 32'h003);
        measure(0, 200, p); check(p == 8, "R9 setup period", p, 8);
        collide(6, g1, g2, g3);
        check(g1 == 8, "R9 coincident write gap1", g1, 8);
        check(g2 == 8, "R9 coincident write gap2 keeps old", g2, 8);
        check(g3 == 4, "R9 coincident write gap3 new", g3, 4);
        wr(3'd1, 32'h003);
        measure(0, 200, p);
        measure(0, 200, p); check(p == 8, "R9 setup period again", p, 8);
        collide(5, g1, g2, g3);
        check(g1 == 8, "R9 early write gap1", g1, 8);
        check(g2 == 4, "R9 early write gap2 new", g2, 4);
        check(g3 == 4, "R9 early write gap3 new", g3, 4);

        // R6/R7/R8: random channel codes and reference patterns
        for (int r = 0; r < 20; r++) begin
            for (int k = 0; k < NCH; k++) begin
                int x;
                x = int'($urandom % 8);
                cd[k] = (x < 4) ? 8'(x) : pool[$urandom % 4];
            end
            wr(3'd3, {cd[3], cd[2], cd[1], cd[0]});
            wr(3'd4, {cd[7], cd[6], cd[5], cd[4]});
            stopm = '0;
            for (int k = 0; k < NCH; k++)
                stopm[k] = !(cd[k] inside {8'h01, 8'h02, 8'h03});
            stopm[NCH] = stopm[NCH-1];
            ref_tick = 4'($urandom);
            for (int k = 0; k < NCH; k++) expv[k] = exp_ch(cd[k], ref_tick);
            expv[NCH] = expv[NCH-1];
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                check(chan_tick == expv, "R6 channel routing", int'(chan_tick), int'(expv));
                check((chan_tick & stopm) == '0, "R7 stopped or unknown code silent",
                      int'(chan_tick & stopm), 0);
                check(chan_tick[NCH] == chan_tick[NCH-1], "R8 channel 8 mirrors 7",
                      int'(chan_tick[NCH]), int'(chan_tick[NCH-1]));
                ref_tick = 4'($urandom);
                for (int k = 0; k < NCH; k++) expv[k] = exp_ch(cd[k], ref_tick);
                expv[NCH] = expv[NCH-1];
            end
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule